// File: doc/BRIEF.md
# Sticky Interrupt Status Aggregator

This block gathers the interrupt causes of a serial peripheral into one interrupt line. It holds three registers. The first is a status register whose bits stay set once an event has set them. The second is a per-cause enable register. The third is a global enable whose top bit gates the line. One-cycle event pulses from the transfer engine set status bits. Two level conditions from the receive queue are merged into the status register whenever the register port is accessed.

Software clears a status bit by writing a 1 to its position. The write is an exclusive-OR with the stored value, so a 1 written over a clear bit sets it. Driver code is expected to write back the value it has just read. The interrupt line is registered. It is high when the global enable bit is set and at least one enabled status bit is pending.

The register port is a simple strobe interface. Write data is sampled on the clock edge. Read data is a combinational function of the address. A cycle counts as an access when the read strobe or the write strobe is high, whatever the address.

Top module: `irq_sticky_agg`

## Requirements
- R1: A synchronous active-low reset clears the status, enable and global enable registers and drives `irq` low.
- R2: The global enable sits at byte offset 0x1C and holds only bit 31. Status sits at 0x20 and enable at 0x28. Both keep only the implemented bits 2, 3, 4, 5, 6 and 8 (mask 0x17C) and read 0 elsewhere. Any other address reads 0, and a write to it changes no register.
- R3: Status bits are set by event pulses as follows. `ev_byte_done` sets bit 2 (transmit empty) and bit 8 (receive not empty). `ev_rx_fill` sets bit 4 (receive full). `ev_rx_overrun` sets bit 5. `ev_tx_underrun` sets bit 3. `ev_tx_half_empty` sets bit 6.
- R4: A write to 0x20 replaces status with status XOR write data, limited to the implemented bits. A 1 toggles its bit, so it also sets a clear bit, and a 0 leaves the bit unchanged.
- R5: An event pulse arriving in the same cycle as a toggle write leaves its status bit set.
- R6: In a cycle with a read or write strobe (any address), `lvl_rx_nonempty` is OR-ed into bit 8 and `lvl_rx_full` into bit 4, after any toggle. Without a strobe the levels have no effect.
- R7: `irq` equals, one cycle later, global enable bit AND (status AND enable is nonzero).
- R8: A set status bit stays set until a toggle write to 0x20 or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (marks an access) |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| ev_byte_done | input | 1 | Pulse: one byte moved |
| ev_rx_fill | input | 1 | Pulse: receive queue became full |
| ev_rx_overrun | input | 1 | Pulse: received byte dropped |
| ev_tx_underrun | input | 1 | Pulse: transmit queue ran dry |
| ev_tx_half_empty | input | 1 | Pulse: transmit queue half empty |
| lvl_rx_nonempty | input | 1 | Level: receive queue holds data |
| lvl_rx_full | input | 1 | Level: receive queue is full |
| irq | output | 1 | Registered interrupt request |

## Verification
Several properties are checked on every cycle. The interrupt line must follow the previous cycle's qualified pending state, and a status bit may drop only after a write to the status offset. Each event pulse must leave its bit set, a strobed cycle with the non-empty level high must leave bit 8 set, and all state must be zero after reset. Some behaviour shows only in the bench's scenarios. These are the exact toggle results, including the set-by-writing-one quirk, the masking of unimplemented bits and the ignoring of unmapped writes. They also include levels that have no effect without a strobe, and the order of the toggle against events and levels inside one cycle.

// File: rtl/irqagg_pkg.sv
// Shared constants and types for the sticky interrupt aggregator.
// Assumes status bit positions are fixed by the software view.
package irqagg_pkg;
    localparam int TXE_BIT  = 2;   // transmit empty
    localparam int TXU_BIT  = 3;   // transmit underrun
    localparam int RXF_BIT  = 4;   // receive full
    localparam int RXO_BIT  = 5;   // receive overrun
    localparam int TXH_BIT  = 6;   // transmit half empty
    localparam int RXNE_BIT = 8;   // receive not empty
    localparam int STS_SPAN = 9;

    localparam logic [STS_SPAN-1:0] STS_IMPL =
        STS_SPAN'((1 << TXE_BIT) | (1 << TXU_BIT) | (1 << RXF_BIT) |
                  (1 << RXO_BIT) | (1 << TXH_BIT) | (1 << RXNE_BIT));

    typedef struct packed {
        logic byte_done;
        logic rx_fill;
        logic rx_overrun;
        logic tx_underrun;
        logic tx_half_empty;
    } evt_t;

    typedef struct packed {
        logic rx_nonempty;
        logic rx_full;
    } lvl_t;
endpackage

// File: rtl/irqagg_decode.sv
// Address decode for the aggregator register port.
// Assumes word-aligned offsets compared over the full address.
module irqagg_decode #(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] GIE_OFS = 'h1C,
    parameter logic [ADDR_W-1:0] STS_OFS = 'h20,
    parameter logic [ADDR_W-1:0] IER_OFS = 'h28
) (
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_gie,
    output logic              hit_sts,
    output logic              hit_ier,
    output logic              wr_gie,
    output logic              wr_sts,
    output logic              wr_ier,
    output logic              access
);
    // Match the address against each register offset.
    always_comb begin
        hit_gie = (addr == GIE_OFS);
        hit_sts = (addr == STS_OFS);
        hit_ier = (addr == IER_OFS);
    end

    // Qualify matches with the write strobe; flag any strobed cycle.
    always_comb begin
        wr_gie = wr && hit_gie;
        wr_sts = wr && hit_sts;
        wr_ier = wr && hit_ier;
        access = wr || rd;
    end
endmodule

// File: rtl/irqagg_status.sv
// Sticky status register: the write toggles, events and strobed levels set.
// Assumes events are single-cycle pulses; unimplemented bits stay zero.
module irqagg_status
    import irqagg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sts,
    input  logic [DATA_W-1:0] wdata,
    input  evt_t              evt,
    input  lvl_t              lvl,
    input  logic              access,
    output logic [DATA_W-1:0] sts_q
);
    localparam logic [DATA_W-1:0] IMPL = DATA_W'(STS_IMPL);

    logic [DATA_W-1:0] set_v;
    logic [DATA_W-1:0] lvl_v;
    logic [DATA_W-1:0] nxt;

    // Map event pulses onto their status positions.
    always_comb begin
        set_v           = '0;
        set_v[TXE_BIT]  = evt.byte_done;
        set_v[RXNE_BIT] = evt.byte_done;
        set_v[RXF_BIT]  = evt.rx_fill;
        set_v[RXO_BIT]  = evt.rx_overrun;
        set_v[TXU_BIT]  = evt.tx_underrun;
        set_v[TXH_BIT]  = evt.tx_half_empty;
    end

    // Levels are merged only in a strobed cycle.
    always_comb begin
        lvl_v = '0;
        if (access) begin
            lvl_v[RXNE_BIT] = lvl.rx_nonempty;
            lvl_v[RXF_BIT]  = lvl.rx_full;
        end
    end

    // Toggle first, then OR sources, then keep implemented bits.
    always_comb begin
        nxt = sts_q;
        if (wr_sts) begin
            nxt = nxt ^ wdata;
        end
        nxt = (nxt | set_v | lvl_v) & IMPL;
    end

    // Status register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= '0;
        end else begin
            sts_q <= nxt;
        end
    end
endmodule

// File: rtl/irqagg_ctl_regs.sv
// Per-cause enable register and global enable flag.
// Assumes the enable register keeps the same implemented bits as status.
module irqagg_ctl_regs
    import irqagg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ier,
    input  logic              wr_gie,
    input  logic [DATA_W-1:0] wdata,
    input  logic              gie_wbit,
    output logic [DATA_W-1:0] ier_q,
    output logic              gie_q
);
    localparam logic [DATA_W-1:0] IMPL = DATA_W'(STS_IMPL);

    // Enable register load, masked to implemented causes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ier_q <= '0;
        end else if (wr_ier) begin
            ier_q <= wdata & IMPL;
        end
    end

    // Global enable flag load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie_q <= 1'b0;
        end else if (wr_gie) begin
            gie_q <= gie_wbit;
        end
    end
endmodule

// File: rtl/irqagg_irq_out.sv
// Registered interrupt request: global enable and any enabled pending cause.
// Assumes one cycle of latency is acceptable to the interrupt controller.
module irqagg_irq_out #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] sts,
    input  logic [DATA_W-1:0] ier,
    input  logic              gie,
    output logic              irq
);
    logic pending;

    // Reduce the enabled pending causes to one bit.
    always_comb begin
        pending = gie && (|(sts & ier));
    end

    // Register the request so the line is glitch free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= pending;
        end
    end
endmodule

// File: rtl/irq_sticky_agg.sv
// Top of the sticky interrupt aggregator: decode, registers, read mux, line.
// Assumes reg_rdata is consumed in the same cycle as reg_addr.
module irq_sticky_agg
    import irqagg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] GIE_OFS = 'h1C,
    parameter logic [ADDR_W-1:0] STS_OFS = 'h20,
    parameter logic [ADDR_W-1:0] IER_OFS = 'h28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ev_byte_done,
    input  logic              ev_rx_fill,
    input  logic              ev_rx_overrun,
    input  logic              ev_tx_underrun,
    input  logic              ev_tx_half_empty,
    input  logic              lvl_rx_nonempty,
    input  logic              lvl_rx_full,
    output logic              irq
);
    localparam int GIE_BIT = DATA_W - 1;

    logic hit_gie, hit_sts, hit_ier;
    logic wr_gie, wr_sts, wr_ier, access;
    logic [DATA_W-1:0] sts_q;
    logic [DATA_W-1:0] ier_q;
    logic gie_q;
    evt_t evt;
    lvl_t lvl;

    // Bundle the event and level pins.
    always_comb begin
        evt.byte_done     = ev_byte_done;
        evt.rx_fill       = ev_rx_fill;
        evt.rx_overrun    = ev_rx_overrun;
        evt.tx_underrun   = ev_tx_underrun;
        evt.tx_half_empty = ev_tx_half_empty;
        lvl.rx_nonempty   = lvl_rx_nonempty;
        lvl.rx_full       = lvl_rx_full;
    end

    irqagg_decode #(
        .ADDR_W (ADDR_W),
        .GIE_OFS(GIE_OFS),
        .STS_OFS(STS_OFS),
        .IER_OFS(IER_OFS)
    ) dec_i (
        .wr     (reg_wr),
        .rd     (reg_rd),
        .addr   (reg_addr),
        .hit_gie(hit_gie),
        .hit_sts(hit_sts),
        .hit_ier(hit_ier),
        .wr_gie (wr_gie),
        .wr_sts (wr_sts),
        .wr_ier (wr_ier),
        .access (access)
    );

    irqagg_status #(.DATA_W(DATA_W)) sts_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_sts(wr_sts),
        .wdata (reg_wdata),
        .evt   (evt),
        .lvl   (lvl),
        .access(access),
        .sts_q (sts_q)
    );

    irqagg_ctl_regs #(.DATA_W(DATA_W)) ctl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ier  (wr_ier),
        .wr_gie  (wr_gie),
        .wdata   (reg_wdata),
        .gie_wbit(reg_wdata[GIE_BIT]),
        .ier_q   (ier_q),
        .gie_q   (gie_q)
    );

    irqagg_irq_out #(.DATA_W(DATA_W)) out_i (
        .clk  (clk),
        .rst_n(rst_n),
        .sts  (sts_q),
        .ier  (ier_q),
        .gie  (gie_q),
        .irq  (irq)
    );

    // Read mux; unmapped offsets return zero.
    always_comb begin
        reg_rdata = '0;
        if (hit_gie) begin
            reg_rdata[GIE_BIT] = gie_q;
        end else if (hit_sts) begin
            reg_rdata = sts_q;
        end else if (hit_ier) begin
            reg_rdata = ier_q;
        end
    end
endmodule

// File: rtl/irq_sticky_agg_chk.sv
// Property checker for the sticky interrupt aggregator, bound to the top.
// Assumes the status offset parameter matches the bound instance.
module irq_sticky_agg_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] STS_OFS = 'h20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              ev_byte_done,
    input logic              ev_tx_underrun,
    input logic              lvl_rx_nonempty,
    input logic [DATA_W-1:0] sts_q,
    input logic [DATA_W-1:0] ier_q,
    input logic              gie_q,
    input logic              irq
);
    logic past_valid;
    logic in_rst_q = 1'b0;

    // Track that the previous edge was out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            past_valid <= 1'b0;
        end else begin
            past_valid <= 1'b1;
        end
    end

    // Track that the previous edge applied reset.
    always_ff @(posedge clk) begin
        in_rst_q <= !rst_n;
    end

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        in_rst_q |-> (sts_q == '0 && ier_q == '0 && !gie_q && !irq));

    // R7
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid |-> (irq == $past(gie_q && (|(sts_q & ier_q)))));

    // R8
    sts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && (|($past(sts_q) & ~sts_q))) |->
            $past(reg_wr && reg_addr == STS_OFS));

    // R3
    byte_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && $past(ev_byte_done)) |-> (sts_q[2] && sts_q[8]));

    // R5
    under_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && $past(ev_tx_underrun)) |-> sts_q[3]);

    // R6
    lvl_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && $past((reg_wr || reg_rd) && lvl_rx_nonempty)) |-> sts_q[8]);
endmodule

bind irq_sticky_agg irq_sticky_agg_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .STS_OFS(STS_OFS)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_wr         (reg_wr),
    .reg_rd         (reg_rd),
    .reg_addr       (reg_addr),
    .ev_byte_done   (ev_byte_done),
    .ev_tx_underrun (ev_tx_underrun),
    .lvl_rx_nonempty(lvl_rx_nonempty),
    .sts_q          (sts_q),
    .ier_q          (ier_q),
    .gie_q          (gie_q),
    .irq            (irq)
);

// File: tb/irq_sticky_agg_tb_top.sv
module irq_sticky_agg_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 17;

    // ev: [0] byte_done [1] rx_fill [2] rx_overrun [3] tx_underrun [4] tx_half_empty
    // lv: [0] rx_nonempty [1] rx_full
    typedef struct packed {
        logic        wr;
        logic        rd;
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic [4:0]  ev;
        logic [1:0]  lv;
        logic [31:0] exp_sts;
        logic        exp_irq;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 8'h00, 32'h0,        5'b00001, 2'b00, 32'h104, 1'b0, 4'd3}, // R3 byte
        '{1'b1, 1'b0, 8'h28, 32'h004,      5'b00000, 2'b00, 32'h104, 1'b0, 4'd7}, // R7 gie off
        '{1'b1, 1'b0, 8'h1C, 32'h80000000, 5'b00000, 2'b00, 32'h104, 1'b1, 4'd7}, // R7
        '{1'b1, 1'b0, 8'h20, 32'h004,      5'b00000, 2'b00, 32'h100, 1'b0, 4'd4}, // R4 clear
        '{1'b1, 1'b0, 8'h20, 32'h008,      5'b00000, 2'b00, 32'h108, 1'b0, 4'd4}, // R4 set by 1
        '{1'b1, 1'b0, 8'h28, 32'h00C,      5'b00000, 2'b00, 32'h108, 1'b1, 4'd7}, // R7
        '{1'b1, 1'b0, 8'h20, 32'h008,      5'b01000, 2'b00, 32'h108, 1'b1, 4'd5}, // R5
        '{1'b1, 1'b0, 8'h20, 32'h108,      5'b00000, 2'b00, 32'h000, 1'b0, 4'd4}, // R4
        '{1'b0, 1'b0, 8'h20, 32'h0,        5'b00000, 2'b11, 32'h000, 1'b0, 4'd6}, // R6 no strobe
        '{1'b0, 1'b1, 8'h1C, 32'h0,        5'b00000, 2'b11, 32'h110, 1'b0, 4'd6}, // R6 read
        '{1'b1, 1'b0, 8'h28, 32'h110,      5'b00000, 2'b00, 32'h110, 1'b1, 4'd7}, // R7
        '{1'b1, 1'b0, 8'h20, 32'h110,      5'b00000, 2'b11, 32'h110, 1'b1, 4'd6}, // R6 after toggle
        '{1'b1, 1'b0, 8'h20, 32'h110,      5'b00000, 2'b00, 32'h000, 1'b0, 4'd4}, // R4
        '{1'b0, 1'b0, 8'h00, 32'h0,        5'b10110, 2'b00, 32'h070, 1'b1, 4'd3}, // R3 others
        '{1'b1, 1'b0, 8'h1C, 32'h0,        5'b00000, 2'b00, 32'h070, 1'b0, 4'd7}, // R7 gie off
        '{1'b1, 1'b0, 8'h20, 32'hFFFFFFFF, 5'b00000, 2'b00, 32'h10C, 1'b0, 4'd2}, // R2 mask
        '{1'b1, 1'b0, 8'h40, 32'hFFFFFFFF, 5'b00000, 2'b00, 32'h10C, 1'b0, 4'd8}  // R8 hold
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_addr = 8'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic [4:0]  ev = 5'b0;
    logic [1:0]  lv = 2'b0;
    logic        irq;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_sticky_agg dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .reg_wr          (reg_wr),
        .reg_rd          (reg_rd),
        .reg_addr        (reg_addr),
        .reg_wdata       (reg_wdata),
        .reg_rdata       (reg_rdata),
        .ev_byte_done    (ev[0]),
        .ev_rx_fill      (ev[1]),
        .ev_rx_overrun   (ev[2]),
        .ev_tx_underrun  (ev[3]),
        .ev_tx_half_empty(ev[4]),
        .lvl_rx_nonempty (lv[0]),
        .lvl_rx_full     (lv[1]),
        .irq             (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        reg_wr = 1'b0; reg_rd = 1'b0; ev = '0; lv = '0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        idle();
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        idle();
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        idle();
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        peek(8'h20, d); check("R1 status", d, 32'h0);
        peek(8'h28, d); check("R1 enable", d, 32'h0);
        peek(8'h1C, d); check("R1 global", d, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            reg_wr = VECS[i].wr; reg_rd = VECS[i].rd; reg_addr = VECS[i].addr;
            reg_wdata = VECS[i].wdata; ev = VECS[i].ev; lv = VECS[i].lv;
            @(negedge clk);
            idle();
            reg_addr = 8'h20;
            #1 check($sformatf("R%0d vec%0d status", VECS[i].req, i), reg_rdata, VECS[i].exp_sts);
            @(negedge clk);
            check($sformatf("R%0d vec%0d irq", VECS[i].req, i), {31'b0, irq}, {31'b0, VECS[i].exp_irq});
        end

        // R2 unmapped write left enable and global flag alone
        peek(8'h28, d); check("R2 enable kept", d, 32'h110);
        peek(8'h1C, d); check("R2 global kept", d, 32'h0);
        write(8'h28, 32'hFFFFFFFF);
        peek(8'h28, d); check("R2 enable mask", d, 32'h17C);
        write(8'h1C, 32'hFFFFFFFF);
        peek(8'h1C, d); check("R2 global bit31", d, 32'h80000000);
        peek(8'h24, d); check("R2 unmapped read", d, 32'h0);
        @(negedge clk);
        check("R7 irq on", {31'b0, irq}, 32'h1);

        // R1 reset in mid run
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 irq after reset", {31'b0, irq}, 32'h0);
        rst_n = 1'b1;
        peek(8'h20, d); check("R1 status after reset", d, 32'h0);
        peek(8'h28, d); check("R1 enable after reset", d, 32'h0);
        peek(8'h1C, d); check("R1 global after reset", d, 32'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule